// File: doc/BRIEF.md
# Serial Match-Character Byte Aligner

This block sits on the receive side of a serial data-link channel. It takes one bit per clock, qualified by a bit-valid strobe, and packs the bits into bytes for a receive FIFO. In match mode it holds back all data until a programmable 8-bit match character has been seen in the stream. The search runs either at every bit position (sliding window) or only on octet boundaries. It then reports where the character ended relative to the octet grid and emits the character and every later byte framed from that point. With match mode off it frames bytes on the octet grid directly.

The octet grid starts with the first valid bit taken after the receive enable goes high. Dropping the enable clears the status and restarts the grid. The block also chooses the transmit byte: FIFO data when the transmit FIFO holds something, otherwise an idle byte. That idle byte is the programmable idle character when match mode is on, or all-ones when it is off.

Top module: `ser_match_aligner`

## Requirements
- R1: After reset, rx_byte_vld, match_seen, match_offset and rx_byte are 0, and the idle character register holds 8'hFF.
- R2: A bit is taken only on a cycle with rx_en and rx_bit_vld both 1. The first bit taken after rx_en rises is octet-grid position 0, and positions count 0 to 7 and wrap. Cycles with rx_bit_vld low change nothing.
- R3: With match_mode 0, every bit at grid position 7 completes a byte. rx_byte carries the last 8 bits with the earliest in bit 7, and rx_byte_vld pulses for one cycle, one cycle after the completing bit. The first such byte sets match_seen and sets match_offset to 3'b111.
- R4: With match_mode 1 and octet_only 0, the last 8 taken bits (earliest in bit 7) are compared with match_char after every bit once 8 bits have arrived. On equality, match_seen is set and match_offset takes the grid position (0 to 7) of the character's last bit. 3'b111 means byte-aligned.
- R5: With match_mode 1 and octet_only 1, a match is accepted only when the character's last bit falls on grid position 7.
- R6: In match mode, rx_byte_vld stays 0 until the match. The matched character is output together with the status update. After that, a byte is output after every further 8 taken bits.
- R7: Once matched, the search stops. Further occurrences of the character do not change match_seen, match_offset or the byte framing until rx_en is cleared.
- R8: A cycle with rx_en at 0 clears match_seen, match_offset and the bit and byte counters one cycle later, and no byte is output during it. Re-enabling restarts the grid at position 0.
- R9: When tx_fifo_empty is 0, tx_byte equals tx_fifo_data.
- R10: When tx_fifo_empty is 1 and match_mode is 1, tx_byte equals the idle character register. A clock with idle_wr at 1 loads idle_wdata into it.
- R11: When tx_fifo_empty is 1 and match_mode is 0, tx_byte is 8'hFF whatever the idle register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; low clears the receive state |
| rx_bit_vld | input | 1 | Qualifies rx_bit this cycle |
| rx_bit | input | 1 | Serial receive bit |
| match_mode | input | 1 | 1: gate output on the match character and use the programmable idle byte |
| octet_only | input | 1 | 1: search only on octet boundaries |
| match_char | input | 8 | Match character |
| rx_byte | output | 8 | Aligned receive byte, earliest bit in bit 7 |
| rx_byte_vld | output | 1 | One-cycle strobe for rx_byte |
| match_seen | output | 1 | Match (or first byte) found |
| match_offset | output | 3 | Grid position of the match's last bit; 3'b111 = aligned |
| idle_wr | input | 1 | Load strobe for the idle character |
| idle_wdata | input | 8 | New idle character |
| tx_fifo_empty | input | 1 | Transmit FIFO has no data |
| tx_fifo_data | input | 8 | Transmit FIFO head byte |
| tx_byte | output | 8 | Byte to transmit |

## Verification
The bench plants the match character at unaligned grid positions. A design that counted the offset from the first bit of the character, or from zero instead of the grid start, would report the wrong offset. In octet-only mode, an unaligned copy of the character must be passed over and a later aligned copy taken; a design that ignored the mode would lock early. The bench sends the character again after the lock, so a design that keeps searching would reframe its bytes. It also drops the enable mid-stream, where a design that kept its grid counter would frame the next bytes off by some bits. Gaps in the bit-valid strobe catch a design that counts clocks rather than bits.

// File: rtl/ser_match_aligner.sv
module ser_match_aligner #(
  parameter int DW = 8,
  parameter logic [DW-1:0] IDLE_INIT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_bit_vld,
  input  logic          rx_bit,
  input  logic          match_mode,
  input  logic          octet_only,
  input  logic [DW-1:0] match_char,
  output logic [DW-1:0] rx_byte,
  output logic          rx_byte_vld,
  output logic          match_seen,
  output logic [$clog2(DW)-1:0] match_offset,
  input  logic          idle_wr,
  input  logic [DW-1:0] idle_wdata,
  input  logic          tx_fifo_empty,
  input  logic [DW-1:0] tx_fifo_data,
  output logic [DW-1:0] tx_byte
);
  localparam int OW = $clog2(DW);
  localparam logic [OW-1:0] LAST = OW'(DW - 1);

  logic [DW-1:0] win_q, idle_q;
  logic [OW-1:0] pos_q, run_q;
  logic          full_q, lock_q;

  wire [DW-1:0] win_d    = {win_q[DW-2:0], rx_bit};
  wire          at_edge  = pos_q == LAST;
  wire          full_now = full_q | at_edge;
  wire          char_hit = full_now && (win_d == match_char) && (!octet_only || at_edge);
  wire          hit      = !lock_q && (match_mode ? char_hit : at_edge);
  wire          emit_run = lock_q && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q        <= '0;
      pos_q        <= '0;
      run_q        <= '0;
      full_q       <= 1'b0;
      lock_q       <= 1'b0;
      rx_byte      <= '0;
      rx_byte_vld  <= 1'b0;
      match_seen   <= 1'b0;
      match_offset <= '0;
    end else begin
      rx_byte_vld <= 1'b0;
      if (!rx_en) begin
        win_q        <= '0;
        pos_q        <= '0;
        run_q        <= '0;
        full_q       <= 1'b0;
        lock_q       <= 1'b0;
        match_seen   <= 1'b0;
        match_offset <= '0;
      end else if (rx_bit_vld) begin
        win_q <= win_d;
        pos_q <= pos_q + 1'b1;
        if (at_edge) full_q <= 1'b1;
        if (hit) begin
          lock_q       <= 1'b1;
          run_q        <= '0;
          match_seen   <= 1'b1;
          match_offset <= pos_q;
          rx_byte      <= win_d;
          rx_byte_vld  <= 1'b1;
        end else if (lock_q) begin
          run_q <= run_q + 1'b1;
          if (emit_run) begin
            rx_byte     <= win_d;
            rx_byte_vld <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       idle_q <= IDLE_INIT;
    else if (idle_wr) idle_q <= idle_wdata;
  end

  assign tx_byte = !tx_fifo_empty ? tx_fifo_data :
                   match_mode     ? idle_q       : '1;
endmodule

// File: rtl/ser_match_aligner_chk.sv
module ser_match_aligner_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          match_mode,
  input logic          octet_only,
  input logic          rx_byte_vld,
  input logic          match_seen,
  input logic [$clog2(DW)-1:0] match_offset,
  input logic          tx_fifo_empty,
  input logic [DW-1:0] tx_fifo_data,
  input logic [DW-1:0] tx_byte
);
  a_r6_no_byte_before_match: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_vld |-> match_seen);

  a_r3_first_byte_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(match_seen) && !$past(match_mode)) |-> (match_offset == '1));

  a_r5_octet_search_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(match_seen) && $past(match_mode && octet_only)) |-> (match_offset == '1));

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (match_seen && rx_en) |=> (match_seen && $stable(match_offset)));

  a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!match_seen && !rx_byte_vld && match_offset == '0));

  a_r9_fifo_data_out: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_fifo_empty |-> (tx_byte == tx_fifo_data));

  a_r11_ones_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fifo_empty && !match_mode) |-> (tx_byte == '1));
endmodule

bind ser_match_aligner ser_match_aligner_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .match_mode(match_mode),
  .octet_only(octet_only), .rx_byte_vld(rx_byte_vld), .match_seen(match_seen),
  .match_offset(match_offset), .tx_fifo_empty(tx_fifo_empty),
  .tx_fifo_data(tx_fifo_data), .tx_byte(tx_byte)
);

// File: tb/tb_ser_match_aligner.sv
module tb_ser_match_aligner;
  logic clk = 0, rst_n = 0;
  logic rx_en = 0, rx_bit_vld = 0, rx_bit = 0, match_mode = 0, octet_only = 0;
  logic [7:0] match_char = 8'h7E, idle_wdata = 0, tx_fifo_data = 0;
  logic idle_wr = 0, tx_fifo_empty = 1;
  logic [7:0] rx_byte, tx_byte;
  logic rx_byte_vld, match_seen;
  logic [2:0] match_offset;

  ser_match_aligner dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  bit q[$];
  bit locked = 0;
  int since = 0;
  bit exp_vld = 0, exp_seen = 0;
  int exp_off = 0;
  logic [7:0] exp_byte = 0, exp_idle = 8'hFF;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    exp_vld = 0;
    if (idle_wr) exp_idle = idle_wdata;
    if (!rx_en) begin
      q.delete(); locked = 0; exp_seen = 0; exp_off = 0;
    end else if (rx_bit_vld) begin
      int n, pos;
      logic [7:0] w;
      bit h;
      q.push_back(rx_bit);
      n = q.size();
      pos = (n - 1) % 8;
      w = 0;
      if (n >= 8) for (int i = 0; i < 8; i++) w = {w[6:0], q[n-8+i]};
      if (!locked) begin
        h = match_mode ? (n >= 8 && w == match_char && (!octet_only || pos == 7)) : (pos == 7);
        if (h) begin
          locked = 1; since = 0; exp_seen = 1; exp_off = pos;
          exp_vld = 1; exp_byte = w;
        end
      end else begin
        since++;
        if (since == 8) begin since = 0; exp_vld = 1; exp_byte = w; end
      end
    end
  endtask

  task automatic compare();
    string tr;
    logic [7:0] et;
    chk(cur_req, "rx_byte_vld", rx_byte_vld, exp_vld);
    chk(cur_req, "match_seen", match_seen, exp_seen);
    chk(cur_req, "match_offset", match_offset, exp_off);
    if (exp_vld) chk(cur_req, "rx_byte", rx_byte, exp_byte);
    if (!tx_fifo_empty) begin tr = "R9"; et = tx_fifo_data; end
    else if (match_mode) begin tr = "R10"; et = exp_idle; end
    else begin tr = "R11"; et = 8'hFF; end
    chk(tr, "tx_byte", tx_byte, et);
  endtask

  task automatic step(bit en, bit vld, bit b);
    rx_en = en; rx_bit_vld = vld; rx_bit = b;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    idle_wr = 0;
  endtask

  task automatic send(logic [7:0] v, bit gaps);
    for (int i = 7; i >= 0; i--) begin
      if (gaps && i % 3 == 0) step(1, 0, ~v[i]);
      step(1, 1, v[i]);
    end
  endtask

  task automatic zeros(int k);
    for (int i = 0; i < k; i++) step(1, 1, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cur_req = "R1";
    chk("R1", "rx_byte_vld", rx_byte_vld, 0);
    chk("R1", "match_seen", match_seen, 0);
    chk("R1", "match_offset", match_offset, 0);
    chk("R1", "rx_byte", rx_byte, 0);
    tx_fifo_empty = 1; match_mode = 1; #1;
    chk("R1", "idle reset", tx_byte, 8'hFF);
    match_mode = 0;
    step(0, 0, 0);

    cur_req = "R3";
    send(8'hC3, 0); send(8'h5A, 0); send(8'h01, 0); send(8'hF0, 0);
    step(0, 0, 0);

    cur_req = "R2";
    send(8'h96, 1); send(8'h3C, 1); send(8'hE7, 1);
    step(0, 1, 1);

    cur_req = "R4";
    match_mode = 1; octet_only = 0; match_char = 8'h7E;
    zeros(3); send(8'h7E, 0); send(8'hA1, 0); send(8'h55, 1); send(8'h7E, 0);
    step(0, 0, 0);
    zeros(7); send(8'h7E, 0); send(8'h12, 0);
    step(0, 0, 0);

    cur_req = "R5";
    octet_only = 1;
    zeros(3); send(8'h7E, 0); zeros(5); send(8'h33, 0); send(8'h7E, 0); send(8'h99, 0);
    step(0, 0, 0);

    cur_req = "R6";
    octet_only = 0; match_char = 8'hB4;
    zeros(13); send(8'hB4, 1); send(8'h0F, 0); send(8'hAA, 0);

    cur_req = "R7";
    send(8'hB4, 0); zeros(4); send(8'hB4, 0); send(8'h66, 0);

    cur_req = "R8";
    step(0, 1, 1); step(0, 1, 0);
    zeros(2); send(8'hB4, 0); send(8'h77, 0);
    zeros(4); step(0, 0, 0);
    match_mode = 0;
    zeros(5); step(0, 0, 0);
    send(8'h81, 0); send(8'h42, 0);

    cur_req = "R10";
    tx_fifo_empty = 1; match_mode = 1;
    idle_wdata = 8'h3E; idle_wr = 1; step(1, 0, 0); step(1, 0, 0);
    cur_req = "R11";
    match_mode = 0; step(1, 0, 0);
    cur_req = "R9";
    tx_fifo_empty = 0;
    for (int i = 0; i < 6; i++) begin
      tx_fifo_data = 8'(i * 37 + 5);
      match_mode = i[0];
      step(1, 0, 0);
    end
    tx_fifo_empty = 1; match_mode = 1;
    idle_wdata = 8'hC9; idle_wr = 1; step(1, 0, 0);
    match_mode = 0; step(1, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule